// File: doc/BRIEF.md
# Serial Shift Register with Latched Output

This block is the data path of a simple serial port. An 8-bit register (the width is a parameter) shifts in one bit from the serial input on each sampling event. Its top bit drives the serial output pin through a small holding latch. A companion buffer takes a snapshot of the whole register when a transfer completes, so software has a full transfer's time to collect the result. The CPU can load the register in parallel at any moment and can read both the live register and the buffer.

The shift clock comes from one of two sources. The first is an external serial clock, already synchronous to `clk`. Its rising edge samples the input and its falling edge releases the output. The second is an internal strobe in which each pulse moves one whole bit.

In external mode the output latch is open while the serial clock is low and closed while it is high. New output data therefore appears on the opposite edge from the one that samples input. In internal mode the latch stays open. A counter counts serial clock edges, two per bit. When it wraps, a sticky completion flag is set and the buffer is loaded.

Top module: `ser_shift_latch`

## Requirements
- R1: After a synchronous reset (`rst`=1 at a clock edge), the data register, the buffer, the completion flag, the edge counter and the output pin are all 0.
- R2: With `clk_sel_i`=1 (external), a rising edge of `sclk_i` (1 now, 0 at the previous clock edge) shifts the data register left by one and loads `sdi_i` into bit 0. A falling edge does not shift.
- R3: With `clk_sel_i`=1, while `sclk_i` is high the pin keeps the value that bit 7 had before the rising edge. After the falling edge the pin shows the current bit 7.
- R4: With `clk_sel_i`=0 (internal), each clock with `strobe_i`=1 shifts once, as in R2, and counts as two edges. The pin always equals the current bit 7 while output is enabled.
- R5: A CPU write (`wr_i`=1) loads `wdata_i` into the data register at the next clock edge. While the latch is open, a new bit 7 reaches the pin in that same cycle.
- R6: A CPU write in the same cycle as a shift wins: the register takes `wdata_i`.
- R7: The edge counter has 2·DATA_W states. Completion happens on the edge that wraps it: the 16th edge for DATA_W=8, which in external mode is the falling edge of the 8th bit. After 15 edges the flag is still 0.
- R8: The completion flag stays set until a cycle with `flag_clr_i`=1. If completion and clear fall in the same cycle, the flag ends up set.
- R9: At completion the buffer receives the data register value that results from that edge. At any other time the buffer holds its value.
- R10: With `oe_i`=0, `sdo_o` is 0 and `sdo_en_o` is 0. With `oe_i`=1, `sdo_en_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel_i | input | 1 | 1 = external serial clock, 0 = internal strobe |
| sclk_i | input | 1 | External serial clock, synchronous to clk |
| strobe_i | input | 1 | Internal one-bit shift strobe |
| sdi_i | input | 1 | Serial data input |
| wr_i | input | 1 | CPU write strobe for the data register |
| wdata_i | input | DATA_W | CPU write data |
| flag_clr_i | input | 1 | Clears the completion flag |
| oe_i | input | 1 | Output enable (pin direction) |
| data_o | output | DATA_W | Live data register |
| buf_o | output | DATA_W | Buffer snapshot taken at completion |
| flag_o | output | 1 | Sticky transfer-complete flag |
| sdo_o | output | 1 | Serial output value |
| sdo_en_o | output | 1 | Serial output drive enable |

## Verification
The bench builds the block with its default DATA_W=8, which gives a 4-bit edge counter. At this width the wrap point is reachable in a handful of directed bits: 15 edges leave the flag clear and the 16th sets it. With eight bits, patterns such as 0xA5 and 0x3C change the top bit often. This exposes whether the pin holds the old value through the high phase and updates only after the falling edge. Both clock sources are checked against the same completion point, which exercises the double-step counting of the strobe path.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
   typedef enum logic {
      SRC_INT = 1'b0,
      SRC_EXT = 1'b1
   } clk_src_e;

   localparam int unsigned EDGES_PER_BIT = 2;
endpackage

// File: rtl/ssl_clk_front.sv
module ssl_clk_front
   import ssl_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       ext_sel_i,
   input  logic       sclk_i,
   input  logic       strobe_i,
   output logic       sclk_q_o,
   output logic       shift_o,
   output logic [1:0] step_o
);
   logic sclk_q;
   logic rise, fall;

   always_ff @(posedge clk) begin
      if (rst) sclk_q <= 1'b0;
      else     sclk_q <= sclk_i;
   end

   assign rise = sclk_i & ~sclk_q;
   assign fall = ~sclk_i & sclk_q;

   always_comb begin
      if (clk_src_e'(ext_sel_i) == SRC_EXT) begin
         shift_o = rise;
         step_o  = {1'b0, rise | fall};
      end else begin
         shift_o = strobe_i;
         step_o  = strobe_i ? 2'(EDGES_PER_BIT) : 2'd0;
      end
   end

   assign sclk_q_o = sclk_q;

   // R2: a shift in external mode only ever follows a high serial clock
   a_r2_shift_on_rise: assert property (@(posedge clk) disable iff (rst)
      (ext_sel_i && shift_o) |=> sclk_q_o);
endmodule

// File: rtl/ssl_shifter.sv
module ssl_shifter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              shift_i,
   input  logic              sdi_i,
   output logic [DATA_W-1:0] data_q_o,
   output logic [DATA_W-1:0] data_d_o
);
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] shifted;

   assign shifted[0] = sdi_i;
   for (genvar i = 1; i < DATA_W; i++) begin : g_bit
      assign shifted[i] = data_q[i-1];
   end

   always_comb begin
      if (wr_i)         data_d_o = wdata_i;
      else if (shift_i) data_d_o = shifted;
      else              data_d_o = data_q;
   end

   always_ff @(posedge clk) begin
      if (rst) data_q <= '0;
      else     data_q <= data_d_o;
   end

   assign data_q_o = data_q;

   // R6: the CPU write always lands, even against a shift
   a_r6_write_wins: assert property (@(posedge clk) disable iff (rst)
      wr_i |=> data_q_o == $past(wdata_i));
   // R2: a shift moves every bit up one place and takes in the serial input
   a_r2_shift_left: assert property (@(posedge clk) disable iff (rst)
      (!wr_i && shift_i) |=> data_q_o == {$past(data_q_o[DATA_W-2:0]), $past(sdi_i)});
endmodule

// File: rtl/ssl_out_latch.sv
module ssl_out_latch (
   input  logic clk,
   input  logic rst,
   input  logic open_i,
   input  logic msb_i,
   input  logic oe_i,
   output logic sdo_o,
   output logic sdo_en_o
);
   logic held_q;
   logic level;

   always_ff @(posedge clk) begin
      if (rst)         held_q <= 1'b0;
      else if (open_i) held_q <= msb_i;
   end

   assign level    = open_i ? msb_i : held_q;
   assign sdo_o    = oe_i & level;
   assign sdo_en_o = oe_i;

   // R3: while the latch stays closed the pin level does not move
   a_r3_hold_closed: assert property (@(posedge clk) disable iff (rst)
      (!open_i && !$past(open_i) && oe_i && $past(oe_i)) |-> $stable(sdo_o));
endmodule

// File: rtl/ssl_xfer_ctrl.sv
module ssl_xfer_ctrl #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        step_i,
   input  logic              clr_i,
   input  logic [DATA_W-1:0] data_d_i,
   output logic              flag_o,
   output logic [DATA_W-1:0] buf_o
);
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W:0]    sum;
   logic              done;
   logic              flag_q;
   logic [DATA_W-1:0] buf_q;

   assign sum  = {1'b0, cnt_q} + (CNT_W+1)'(step_i);
   assign done = sum[CNT_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
         buf_q  <= '0;
      end else begin
         cnt_q <= sum[CNT_W-1:0];
         if (done)       flag_q <= 1'b1;
         else if (clr_i) flag_q <= 1'b0;
         if (done)       buf_q  <= data_d_i;
      end
   end

   assign flag_o = flag_q;
   assign buf_o  = buf_q;

   // R8: the flag survives until a clear arrives
   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (flag_o && !clr_i) |=> flag_o);
   // R9: the buffer moves only at completion
   a_r9_buf_hold: assert property (@(posedge clk) disable iff (rst)
      !done |=> $stable(buf_o));
endmodule

// File: rtl/ser_shift_latch.sv
module ser_shift_latch
   import ssl_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clk_sel_i,
   input  logic              sclk_i,
   input  logic              strobe_i,
   input  logic              sdi_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              flag_clr_i,
   input  logic              oe_i,
   output logic [DATA_W-1:0] data_o,
   output logic [DATA_W-1:0] buf_o,
   output logic              flag_o,
   output logic              sdo_o,
   output logic              sdo_en_o
);
   localparam int unsigned CNT_W = $clog2(EDGES_PER_BIT * DATA_W);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("ser_shift_latch: DATA_W must be a power of two, at least 2");
   end

   logic       sclk_q;
   logic       shift;
   logic [1:0] step;
   logic [DATA_W-1:0] data_d;
   logic       latch_open;

   ssl_clk_front u_front (
      .clk(clk), .rst(rst), .ext_sel_i(clk_sel_i), .sclk_i(sclk_i),
      .strobe_i(strobe_i), .sclk_q_o(sclk_q), .shift_o(shift), .step_o(step)
   );

   ssl_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst(rst), .wr_i(wr_i), .wdata_i(wdata_i), .shift_i(shift),
      .sdi_i(sdi_i), .data_q_o(data_o), .data_d_o(data_d)
   );

   assign latch_open = (clk_src_e'(clk_sel_i) == SRC_INT) | ~sclk_q;

   ssl_out_latch u_latch (
      .clk(clk), .rst(rst), .open_i(latch_open), .msb_i(data_o[DATA_W-1]),
      .oe_i(oe_i), .sdo_o(sdo_o), .sdo_en_o(sdo_en_o)
   );

   ssl_xfer_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst(rst), .step_i(step), .clr_i(flag_clr_i),
      .data_d_i(data_d), .flag_o(flag_o), .buf_o(buf_o)
   );

   // R4: with the internal source the pin follows the top bit directly
   a_r4_internal_follow: assert property (@(posedge clk) disable iff (rst)
      !clk_sel_i |-> sdo_o == (oe_i & data_o[DATA_W-1]));
   // R10: output disabled means the pin is released and low
   a_r10_release: assert property (@(posedge clk) disable iff (rst)
      !oe_i |-> (!sdo_o && !sdo_en_o));
endmodule

// File: tb/ser_shift_latch_test.sv
module ser_shift_latch_test;
   localparam int W = 8;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic clk_sel = 1'b0, sclk = 1'b0, strobe = 1'b0, sdi = 1'b0;
   logic wr = 1'b0, clr = 1'b0, oe = 1'b0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] data_o, buf_o;
   logic flag_o, sdo_o, sdo_en_o;
   int n_chk = 0, n_bad = 0;
   logic [W-1:0] exp_d;

   always #2 clk = ~clk;

   ser_shift_latch #(.DATA_W(W)) uut (
      .clk(clk), .rst(rst), .clk_sel_i(clk_sel), .sclk_i(sclk), .strobe_i(strobe),
      .sdi_i(sdi), .wr_i(wr), .wdata_i(wdata), .flag_clr_i(clr), .oe_i(oe),
      .data_o(data_o), .buf_o(buf_o), .flag_o(flag_o), .sdo_o(sdo_o), .sdo_en_o(sdo_en_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic do_reset(input logic src);
      @(negedge clk);
      rst = 1'b1; clk_sel = src; sclk = 0; strobe = 0; sdi = 0; wr = 0; clr = 0; oe = 1;
      tick();
      @(negedge clk); rst = 1'b0;
      exp_d = '0;
   endtask

   task automatic cpu_write(input logic [W-1:0] v);
      @(negedge clk); wr = 1; wdata = v;
      tick();
      @(negedge clk); wr = 0;
      exp_d = v;
   endtask

   // one external bit: rising edge then falling edge, checks latch behaviour
   task automatic ext_bit(input logic b);
      logic old_msb;
      old_msb = exp_d[W-1];
      @(negedge clk); sdi = b; sclk = 1;
      tick();
      exp_d = {exp_d[W-2:0], b};
      check("R2 shift on rise", data_o, exp_d);
      check("R3 hold while high", sdo_o, old_msb);
      @(negedge clk); sclk = 0;
      tick();
      check("R3 update after fall", sdo_o, exp_d[W-1]);
   endtask

   task automatic t_reset();
      @(negedge clk); rst = 1; oe = 1; sdi = 1; sclk = 0;
      tick();
      check("R1 data", data_o, 0);
      check("R1 buffer", buf_o, 0);
      check("R1 flag", flag_o, 0);
      check("R1 pin", sdo_o, 0);
   endtask

   task automatic t_write_and_release();
      do_reset(1'b0);
      cpu_write(8'h80);
      check("R5 data loaded", data_o, 8'h80);
      check("R5 pin shows new msb", sdo_o, 1);
      @(negedge clk); oe = 0; #1;
      check("R10 pin low when disabled", sdo_o, 0);
      check("R10 enable low", sdo_en_o, 0);
      @(negedge clk); oe = 1; #1;
      check("R10 enable high", sdo_en_o, 1);
   endtask

   task automatic t_ext_transfer();
      logic [W-1:0] pat;
      pat = 8'h3C;
      do_reset(1'b1);
      cpu_write(8'hA5);
      check("R5 pin while open", sdo_o, 1);
      for (int i = W-1; i >= 1; i--) ext_bit(pat[i]);
      // 8th bit: rise only -> 15 edges
      @(negedge clk); sdi = pat[0]; sclk = 1;
      tick();
      exp_d = {exp_d[W-2:0], pat[0]};
      check("R7 no flag after 15 edges", flag_o, 0);
      check("R9 buffer untouched mid transfer", buf_o, 0);
      @(negedge clk); sclk = 0;
      tick();
      check("R7 flag on 16th edge", flag_o, 1);
      check("R9 buffer snapshot", buf_o, pat);
      check("R2 full pattern", data_o, pat);
      // R8 sticky then clear
      tick();
      check("R8 flag sticky", flag_o, 1);
      @(negedge clk); clr = 1;
      tick();
      @(negedge clk); clr = 0;
      check("R8 flag cleared", flag_o, 0);
      check("R9 buffer holds after clear", buf_o, pat);
   endtask

   task automatic t_int_transfer();
      logic [W-1:0] pat;
      pat = 8'h96;
      do_reset(1'b0);
      for (int i = W-1; i >= 0; i--) begin
         @(negedge clk); sdi = pat[i]; strobe = 1;
         tick();
         exp_d = {exp_d[W-2:0], pat[i]};
         check("R4 strobe shift", data_o, exp_d);
         check("R4 pin follows msb", sdo_o, exp_d[W-1]);
         if (i == 1) check("R7 no flag after 7 strobes", flag_o, 0);
      end
      @(negedge clk); strobe = 0;
      check("R4 flag after 8 strobes", flag_o, 1);
      check("R9 buffer gets shifted value", buf_o, pat);
   endtask

   task automatic t_set_beats_clear();
      do_reset(1'b0);
      @(negedge clk); strobe = 1;
      repeat (7) tick();
      check("R8 flag clear before wrap", flag_o, 0);
      @(negedge clk); clr = 1;
      tick();
      @(negedge clk); strobe = 0; clr = 0;
      check("R8 set wins over clear", flag_o, 1);
   endtask

   task automatic t_write_priority();
      do_reset(1'b1);
      @(negedge clk); wr = 1; wdata = 8'h5A; sclk = 1; sdi = 1;
      tick();
      @(negedge clk); wr = 0; sclk = 0;
      check("R6 write beats shift", data_o, 8'h5A);
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_write_and_release();
      t_ext_transfer();
      t_int_transfer();
      t_set_beats_clear();
      t_write_priority();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule